// File: doc/BRIEF.md
# Self-Synchronizing Pseudo-Random Bit Error Tester

This block measures the quality of a serial link with a pseudo-random test pattern. A transmit linear feedback shift register (LFSR) generates the outgoing bit stream, one bit per valid strobe. On the far side, a receive LFSR of the same length acquires the pattern directly from the arriving bits. No framing word or marker is needed.

While it is seeding, the receiver's feedback loop is open, and each received bit shifts straight into its register. Once a full register's worth of bits has been loaded, the loop closes. The receiver then free-runs as a predictor. Each arriving bit is compared with the predicted bit, and mismatches are counted. The block also counts every compared bit, so an error rate can be formed outside it.

A corrupted seed would leave the predictor on the wrong phase. To catch this, the first stretch of compared bits after lock is watched closely. If too many mismatches appear there, the lock is dropped and seeding starts again from fresh bits.

Top module: `prbs_bert`

## Requirements
- R1: While reset is held, `locked` is 0 and both counters read 0. The first transmitted bit is the MSB of the nonzero reset seed (default 8'hA5, so the first bit is 1).
- R2: The transmit LFSR advances one step per valid bit and outputs its MSB. For the default polynomial x^8+x^6+x^5+x^4+1, the stream obeys b[k+8] = b[k] ^ b[k+2] ^ b[k+3] ^ b[k+4], and no 8 consecutive bits are all zero.
- R3: After reset, a start request or a dropped lock, `locked` rises right after exactly 8 (the LFSR length) valid bits have been loaded. Compare results have no effect during this loading.
- R4: While locked, every valid bit increments `bitCount` by 1. Every valid bit that differs from the prediction also increments `errCount` by 1.
- R5: Cycles with `bitValid` low change neither counter nor the predictor state, whatever `rxBit` carries.
- R6: If more than 4 mismatches occur within the first 64 compared bits after lock, the block does three things on the bit that brings the count over 4: it drops `locked`, clears both counters, and restarts seeding.
- R7: Four or fewer mismatches in that window keep the lock. After the window ends, no number of mismatches drops the lock.
- R8: Both counters saturate at their all-ones value instead of wrapping.
- R9: A start request clears both counters and drops `locked`. The received bit presented in the same cycle is not used as a seed bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bitValid | input | 1 | One link bit is present this cycle |
| startReq | input | 1 | Clear counters and resynchronize |
| txBit | output | 1 | Transmit pattern bit |
| rxBit | input | 1 | Received bit from the link |
| locked | output | 1 | Receive predictor is synchronized |
| errCount | output | CNT_W | Saturating mismatch count |
| bitCount | output | CNT_W | Saturating compared-bit count |

## Verification
The assertions take `startReq` and `bitValid` to be synchronous single-cycle levels that are clean after reset. They also take the received stream to be the transmitted stream with isolated flips, so that a clean seed yields a correct prediction. The stimulus loops `txBit` back to `rxBit` through an XOR with a bench-controlled flip bit. It changes inputs only one time unit after a rising edge, and raises `startReq` only as a single-cycle pulse. All error injection goes through that flip bit: inside the seed, inside and at the edge of the check window, and after it.

// File: rtl/prbs_bert_pkg.sv
package prbs_bert_pkg;

  typedef enum logic [1:0] {
    ST_SEED  = 2'd0,
    ST_CHECK = 2'd1,
    ST_RUN   = 2'd2
  } bertState_t;

  typedef struct packed {
    logic seedShift;
    logic compareEn;
    logic clearCounts;
  } bertStrobe_t;

endpackage

// File: rtl/prbs_lfsr.sv
module prbs_lfsr #(
  parameter int              LFSR_LEN  = 8,
  parameter logic [LFSR_LEN-1:0] LFSR_TAPS = 8'b1011_1000,
  parameter logic [LFSR_LEN-1:0] TX_SEED   = 8'hA5
) (
  input  logic clk,
  input  logic rstN,
  input  logic advance,
  output logic outBit
);

  logic [LFSR_LEN-1:0] state;
  logic                fbBit;

  assign fbBit  = ^(state & LFSR_TAPS);
  assign outBit = state[LFSR_LEN-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        state <= TX_SEED;
    else if (advance) state <= {state[LFSR_LEN-2:0], fbBit};
  end

  // R2
  txNonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    state != '0);

endmodule

// File: rtl/prbs_bert_dp.sv
module prbs_bert_dp
  import prbs_bert_pkg::*;
#(
  parameter int              LFSR_LEN  = 8,
  parameter logic [LFSR_LEN-1:0] LFSR_TAPS = 8'b1011_1000,
  parameter int              CNT_W     = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  bertStrobe_t      strobe,
  input  logic             rxBit,
  output logic             mismatch,
  output logic [CNT_W-1:0] errCount,
  output logic [CNT_W-1:0] bitCount
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [LFSR_LEN-1:0] rxState;
  logic                predBit;

  assign predBit  = ^(rxState & LFSR_TAPS);
  assign mismatch = rxBit ^ predBit;

  // open loop while seeding, closed loop while predicting
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 rxState <= '0;
    else if (strobe.seedShift) rxState <= {rxState[LFSR_LEN-2:0], rxBit};
    else if (strobe.compareEn) rxState <= {rxState[LFSR_LEN-2:0], predBit};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errCount <= '0;
      bitCount <= '0;
    end else if (strobe.clearCounts) begin
      errCount <= '0;
      bitCount <= '0;
    end else if (strobe.compareEn) begin
      if (bitCount != CNT_MAX)             bitCount <= bitCount + 1'b1;
      if (mismatch && errCount != CNT_MAX) errCount <= errCount + 1'b1;
    end
  end

  // R4
  errNotAboveBits_chk: assert property (@(posedge clk) disable iff (!rstN)
    errCount <= bitCount);

  // R8
  errSaturate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errCount == CNT_MAX && !strobe.clearCounts) |=> errCount == CNT_MAX);

  // R5
  idleHold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.seedShift && !strobe.compareEn && !strobe.clearCounts)
      |=> ($stable(errCount) && $stable(bitCount) && $stable(rxState)));

endmodule

// File: rtl/prbs_bert_ctrl.sv
module prbs_bert_ctrl
  import prbs_bert_pkg::*;
#(
  parameter int LFSR_LEN  = 8,
  parameter int CHECK_WIN = 64,
  parameter int BAD_LIMIT = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        bitValid,
  input  logic        startReq,
  input  logic        mismatch,
  output bertStrobe_t strobe,
  output logic        locked
);

  localparam int SEED_W = $clog2(LFSR_LEN);
  localparam int WIN_W  = $clog2(CHECK_WIN + 1);
  localparam int ERR_W  = $clog2(BAD_LIMIT + 2);

  bertState_t       state;
  logic [SEED_W-1:0] seedCnt;
  logic [WIN_W-1:0]  winCnt;
  logic [ERR_W-1:0]  winErr;
  logic [ERR_W-1:0]  winErrNext;
  logic              step;
  logic              badLock;

  assign step       = bitValid && !startReq;
  assign winErrNext = winErr + ERR_W'(mismatch);
  assign badLock    = (state == ST_CHECK) && step && (winErrNext > ERR_W'(BAD_LIMIT));
  assign locked     = (state != ST_SEED);

  always_comb begin
    strobe.seedShift   = (state == ST_SEED) && step;
    strobe.compareEn   = (state != ST_SEED) && step;
    strobe.clearCounts = startReq || badLock;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_SEED;
      seedCnt <= '0;
      winCnt  <= '0;
      winErr  <= '0;
    end else if (startReq) begin
      state   <= ST_SEED;
      seedCnt <= '0;
      winCnt  <= '0;
      winErr  <= '0;
    end else if (step) begin
      unique case (state)
        ST_SEED: begin
          if (seedCnt == SEED_W'(LFSR_LEN - 1)) begin
            state   <= ST_CHECK;
            seedCnt <= '0;
            winCnt  <= '0;
            winErr  <= '0;
          end else begin
            seedCnt <= seedCnt + 1'b1;
          end
        end
        ST_CHECK: begin
          if (badLock) begin
            state   <= ST_SEED;
            seedCnt <= '0;
          end else if (winCnt == WIN_W'(CHECK_WIN - 1)) begin
            state <= ST_RUN;
          end else begin
            winCnt <= winCnt + 1'b1;
            winErr <= winErrNext;
          end
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  // R3
  lockAfterSeed_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> ($past(seedCnt) == SEED_W'(LFSR_LEN - 1) && $past(step)));

  // R7
  lockHold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (locked && !startReq && !badLock) |=> locked);

  // R6
  winErrBound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CHECK) |-> winErr <= ERR_W'(BAD_LIMIT));

endmodule

// File: rtl/prbs_bert.sv
module prbs_bert
  import prbs_bert_pkg::*;
#(
  parameter int              LFSR_LEN  = 8,
  parameter logic [LFSR_LEN-1:0] LFSR_TAPS = 8'b1011_1000,
  parameter logic [LFSR_LEN-1:0] TX_SEED   = 8'hA5,
  parameter int              CNT_W     = 32,
  parameter int              CHECK_WIN = 64,
  parameter int              BAD_LIMIT = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitValid,
  input  logic             startReq,
  output logic             txBit,
  input  logic             rxBit,
  output logic             locked,
  output logic [CNT_W-1:0] errCount,
  output logic [CNT_W-1:0] bitCount
);

  bertStrobe_t strobe;
  logic        mismatch;

  prbs_lfsr #(
    .LFSR_LEN (LFSR_LEN),
    .LFSR_TAPS(LFSR_TAPS),
    .TX_SEED  (TX_SEED)
  ) u_txGen (
    .clk    (clk),
    .rstN   (rstN),
    .advance(bitValid),
    .outBit (txBit)
  );

  prbs_bert_ctrl #(
    .LFSR_LEN (LFSR_LEN),
    .CHECK_WIN(CHECK_WIN),
    .BAD_LIMIT(BAD_LIMIT)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .bitValid(bitValid),
    .startReq(startReq),
    .mismatch(mismatch),
    .strobe  (strobe),
    .locked  (locked)
  );

  prbs_bert_dp #(
    .LFSR_LEN (LFSR_LEN),
    .LFSR_TAPS(LFSR_TAPS),
    .CNT_W    (CNT_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .rxBit   (rxBit),
    .mismatch(mismatch),
    .errCount(errCount),
    .bitCount(bitCount)
  );

endmodule

// File: tb/prbs_bert_bench.sv
module prbs_bert_bench;

  localparam int CLK_PERIOD = 10;
  localparam int LOG_MAX    = 2048;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bitValid = 1'b0;
  logic        startReq = 1'b0;
  logic        flipBit = 1'b0;
  logic        txBit, rxBit, locked, smallTx, smallLocked;
  logic [31:0] errCount, bitCount;
  logic [3:0]  smallErr, smallBits;

  int  nChecks = 0;
  int  nFail   = 0;
  bit  done    = 0;
  int  logIdx  = 0;
  bit  txLog [LOG_MAX];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign rxBit = txBit ^ flipBit;

  prbs_bert u_prbs_bert (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .startReq(startReq),
    .txBit(txBit), .rxBit(rxBit), .locked(locked),
    .errCount(errCount), .bitCount(bitCount)
  );

  prbs_bert #(.CNT_W(4)) u_small (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .startReq(startReq),
    .txBit(smallTx), .rxBit(rxBit), .locked(smallLocked),
    .errCount(smallErr), .bitCount(smallBits)
  );

  task automatic checkEq(input string tag, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic sendBit(input bit flip);
    bitValid = 1'b1;
    flipBit  = flip;
    if (logIdx < LOG_MAX) begin
      txLog[logIdx] = txBit;
      logIdx++;
    end
    @(posedge clk); #1;
    bitValid = 1'b0;
    flipBit  = 1'b0;
  endtask

  task automatic sendClean(input int n);
    for (int i = 0; i < n; i++) sendBit(1'b0);
  endtask

  task automatic pulseStart(input bit withBit);
    startReq = 1'b1;
    if (withBit) sendBit(1'b1);
    else begin @(posedge clk); #1; end
    startReq = 1'b0;
  endtask

  task automatic tReset;
    checkEq("R1 locked in reset", locked, 0);
    checkEq("R1 errCount in reset", errCount, 0);
    checkEq("R1 bitCount in reset", bitCount, 0);
    checkEq("R1 first tx bit", txBit, 1);
  endtask

  task automatic tSeedLock;
    sendClean(7);
    checkEq("R3 not locked after 7 bits", locked, 0);
    sendBit(1'b0);
    checkEq("R3 locked after 8 bits", locked, 1);
  endtask

  task automatic tCleanRun;
    sendClean(100);
    checkEq("R4 clean errCount", errCount, 0);
    checkEq("R4 clean bitCount", bitCount, 100);
  endtask

  task automatic tInjected;
    for (int i = 0; i < 40; i++) sendBit(i == 5 || i == 17 || i == 33);
    checkEq("R4 injected errCount", errCount, 3);
    checkEq("R4 injected bitCount", bitCount, 140);
  endtask

  task automatic tIdle;
    flipBit = 1'b1;
    repeat (5) begin @(posedge clk); #1; end
    flipBit = 1'b0;
    checkEq("R5 idle errCount", errCount, 3);
    checkEq("R5 idle bitCount", bitCount, 140);
    sendBit(1'b0);
    checkEq("R5 predictor intact after idle", errCount, 3);
    checkEq("R5 bitCount after idle", bitCount, 141);
  endtask

  task automatic tStart;
    pulseStart(1'b1);
    checkEq("R9 start drops lock", locked, 0);
    checkEq("R9 start clears errCount", errCount, 0);
    checkEq("R9 start clears bitCount", bitCount, 0);
    sendClean(7);
    checkEq("R9 start bit not a seed", locked, 0);
    sendBit(1'b0);
    checkEq("R9 relock after start", locked, 1);
    sendClean(20);
    checkEq("R9 clean after start", errCount, 0);
  endtask

  task automatic tWindowFour;
    pulseStart(1'b0);
    sendClean(8);
    for (int i = 0; i < 64; i++) sendBit(i == 3 || i == 10 || i == 20 || i == 40);
    checkEq("R7 four window errors keep lock", locked, 1);
    checkEq("R7 four window errCount", errCount, 4);
    for (int i = 0; i < 30; i++) sendBit(i % 3 == 0);
    checkEq("R7 lock held after window", locked, 1);
    checkEq("R7 errCount after window", errCount, 14);
  endtask

  task automatic tWindowFive;
    pulseStart(1'b0);
    sendClean(8);
    for (int i = 0; i < 4; i++) sendBit(1'b1);
    checkEq("R6 four errors still locked", locked, 1);
    checkEq("R6 four errors counted", errCount, 4);
    sendBit(1'b1);
    checkEq("R6 fifth error drops lock", locked, 0);
    checkEq("R6 drop clears errCount", errCount, 0);
    checkEq("R6 drop clears bitCount", bitCount, 0);
    sendClean(8);
    checkEq("R6 relock after drop", locked, 1);
    sendClean(20);
    checkEq("R6 clean after relock", errCount, 0);
  endtask

  task automatic tSeedCorrupt;
    int waited;
    pulseStart(1'b0);
    for (int i = 0; i < 8; i++) sendBit(i == 2);
    checkEq("R6 corrupt seed still locks", locked, 1);
    waited = 0;
    while (locked && waited < 64) begin
      sendBit(1'b0);
      waited++;
    end
    checkEq("R6 bad seed detected", locked, 0);
    sendClean(8);
    checkEq("R6 retry locks", locked, 1);
    sendClean(50);
    checkEq("R6 retry errCount", errCount, 0);
    checkEq("R6 retry bitCount", bitCount, 50);
  endtask

  task automatic tSaturate;
    pulseStart(1'b0);
    sendClean(8);
    sendClean(64);
    for (int i = 0; i < 20; i++) sendBit(1'b1);
    checkEq("R8 wide errCount exact", errCount, 20);
    checkEq("R8 narrow errCount saturates", smallErr, 15);
    checkEq("R8 narrow bitCount saturates", smallBits, 15);
    checkEq("R7 lock kept under burst", locked, 1);
  endtask

  task automatic tTxSequence;
    int bad;
    int zeroRun;
    bad = 0;
    zeroRun = 0;
    for (int k = 0; k + 8 < logIdx; k++)
      if (txLog[k+8] != (txLog[k] ^ txLog[k+2] ^ txLog[k+3] ^ txLog[k+4])) bad++;
    for (int k = 0; k < logIdx; k++) begin
      zeroRun = txLog[k] ? 0 : zeroRun + 1;
      if (zeroRun >= 8) bad++;
    end
    checkEq("R2 tx recurrence violations", bad, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    tReset;
    rstN = 1'b1;
    tSeedLock;
    tCleanRun;
    tInjected;
    tIdle;
    tStart;
    tWindowFour;
    tWindowFive;
    tSeedCorrupt;
    tSaturate;
    tTxSequence;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog R1..all actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

endmodule